// File: doc/BRIEF.md
# Control Endpoint Mode Register with Write Lockout

This block holds the mode and status byte of a USB control endpoint. Two agents share the byte: a CPU that reads and writes it, and a serial interface engine that reports token and handshake events. The low nibble selects how the endpoint answers SETUP, IN and OUT tokens. The upper bits record what the last accepted transaction did: whether it was a SETUP, whether its data arrived intact, and whether it ended in an ACK. Bit 7 belongs to the CPU alone.

When the engine touches the byte, bits 6:0 are locked against CPU writes until the CPU reads the register. This prevents firmware that has not yet seen an engine update from overwriting it. After an acknowledged handshake the engine rewrites the mode on its own, so the endpoint falls back to a safe state. Every completed transaction gives a one-cycle interrupt pulse. Each byte the engine places in the endpoint FIFO also holds the CPU off for a fixed number of cycles.

Top module: `ep_ctl_mode_reg`

## Requirements
- R1: After reset the register reads 0x00, the lock is clear, the interrupt is low and the CPU stall is low.
- R2: The response decode is combinational from the current mode and the token kind. Token kinds are 0=SETUP, 1=IN, 2=OUT, 3=reserved. Responses are 0=ignore, 1=ACK, 2=NAK, 3=STALL. A reserved token, and any mode outside {1,2,3,6,7,15}, gives ignore. In every defined mode a SETUP gives ACK. IN/OUT responses are: mode 1 NAK/NAK, mode 2 STALL/STALL, mode 3 NAK/ACK, mode 6 STALL/ACK, mode 7 ACK/NAK, mode 15 ACK/ACK.
- R3: A token whose response is not ignore is accepted at its end pulse, and the update is visible on the next cycle. Bit 5 becomes 1 exactly for SETUP. Bit 6 (data valid) becomes 1 only for an ACKed SETUP or OUT with CRC good. Bit 4 clears. An ignored token changes nothing and arms nothing.
- R4: A bad CRC leaves bit 6 at 0, but the transaction still produces its interrupt.
- R5: Any engine update (an accepted token, or a handshake of a pending transaction) sets the lock. While the lock is set, and in any cycle with an engine update, CPU writes to bits 6:0 are discarded. Bit 7 is still written.
- R6: A CPU read clears the lock on the next cycle, unless an engine update happens in the same cycle, in which case the lock stays set.
- R7: On a handshake of a pending transaction, bit 4 is set when the stored response was ACK and the handshake was acknowledged. In that case the mode becomes 6 after an IN in mode 15, and 1 in every other case. Otherwise the mode is unchanged.
- R8: The interrupt is high for the cycle after each handshake of a pending transaction. A handshake with no pending transaction is ignored.
- R9: Each engine FIFO byte write adds 3 cycles to the CPU stall. The count drops by one per cycle and saturates at 31.
- R10: When unlocked and with no engine update, a CPU write loads all 8 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rd | input | 1 | CPU read strobe (clears lock) |
| cpu_rdata | output | 8 | Current register value |
| wr_locked | output | 1 | Bits 6:0 locked against CPU writes |
| tok_done | input | 1 | End of token phase pulse |
| tok_type | input | 2 | Token kind of current token |
| crc_ok | input | 1 | Data packet CRC was correct |
| tok_resp | output | 2 | Response decoded for current token |
| hs_done | input | 1 | Handshake phase complete pulse |
| hs_ack | input | 1 | Handshake ended with ACK |
| ep_irq | output | 1 | Endpoint interrupt pulse |
| fifo_wr | input | 1 | Engine wrote one byte into FIFO |
| cpu_stall | output | 1 | CPU held off |

## Verification
The assertions check four properties on every cycle. A locked write never alters bits 6:0. A read without an engine update releases the lock, and any engine update arms it. The interrupt follows exactly the handshakes of pending transactions. IN tokens and bad CRCs never leave data valid set, and a FIFO write always raises the stall. Only the bench scenarios can show the full response table across all sixteen modes, the specific mode rewrites after ACKed handshakes, the ignored-token case, and the stall length with its saturation.

// File: rtl/ep_mode_pkg.sv
package ep_mode_pkg;

    localparam int MODE_W = 4;

    typedef enum logic [1:0] {
        TOK_SETUP = 2'd0,
        TOK_IN    = 2'd1,
        TOK_OUT   = 2'd2,
        TOK_RSVD  = 2'd3
    } tok_kind_e;

    typedef enum logic [1:0] {
        RESP_NONE  = 2'd0,
        RESP_ACK   = 2'd1,
        RESP_NAK   = 2'd2,
        RESP_STALL = 2'd3
    } resp_e;

    typedef enum logic [MODE_W-1:0] {
        MD_OFF        = 4'h0,
        MD_NAK_BOTH   = 4'h1,
        MD_STALL_BOTH = 4'h2,
        MD_ACK_OUT    = 4'h3,
        MD_STATUS_OUT = 4'h6,
        MD_ACK_IN     = 4'h7,
        MD_IN_STATUS  = 4'hF
    } mode_e;

    typedef struct packed {
        logic             cpu_flag;
        logic             dval;
        logic             setup;
        logic             acked;
        logic [MODE_W-1:0] mode;
    } ep_reg_t;

    function automatic resp_e decode_resp(logic [MODE_W-1:0] m, tok_kind_e t);
        resp_e r;
        r = RESP_NONE;
        if (t != TOK_RSVD) begin
            case (m)
                MD_NAK_BOTH:   r = (t == TOK_SETUP) ? RESP_ACK : RESP_NAK;
                MD_STALL_BOTH: r = (t == TOK_SETUP) ? RESP_ACK : RESP_STALL;
                MD_ACK_OUT:    r = (t == TOK_IN) ? RESP_NAK : RESP_ACK;
                MD_STATUS_OUT: r = (t == TOK_IN) ? RESP_STALL : RESP_ACK;
                MD_ACK_IN:     r = (t == TOK_OUT) ? RESP_NAK : RESP_ACK;
                MD_IN_STATUS:  r = RESP_ACK;
                default:       r = RESP_NONE;
            endcase
        end
        return r;
    endfunction

    function automatic logic [MODE_W-1:0] next_mode(logic [MODE_W-1:0] m, tok_kind_e t);
        if (t == TOK_IN && m == MD_IN_STATUS)
            return MD_STATUS_OUT;
        return MD_NAK_BOTH;
    endfunction

endpackage

// File: rtl/ep_resp_decode.sv
module ep_resp_decode
    import ep_mode_pkg::*;
(
    input  logic [MODE_W-1:0] mode,
    input  tok_kind_e         tok,
    output resp_e             resp
);
    always_comb resp = decode_resp(mode, tok);
endmodule

// File: rtl/ep_lock_ctrl.sv
module ep_lock_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic eng_upd,
    input  logic cpu_rd,
    output logic locked
);
    always_ff @(posedge clk) begin
        if (rst)
            locked <= 1'b0;
        else if (eng_upd)
            locked <= 1'b1;
        else if (cpu_rd)
            locked <= 1'b0;
    end
endmodule

// File: rtl/ep_stall_timer.sv
module ep_stall_timer #(
    parameter int CYC_PER_BYTE = 3,
    parameter int CNT_W        = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic byte_wr,
    output logic stall
);
    localparam logic [CNT_W:0] MAX_CNT = {1'b0, {CNT_W{1'b1}}};
    localparam logic [CNT_W:0] ADD     = CYC_PER_BYTE[CNT_W:0];

    generate
        if (CYC_PER_BYTE == 0) begin : g_none
            assign stall = 1'b0;
        end else begin : g_cnt
            logic [CNT_W-1:0] cnt_q;
            logic [CNT_W:0]   sum;

            always_comb begin
                sum = {1'b0, cnt_q};
                if (cnt_q != '0) sum = sum - 1'b1;
                if (byte_wr)     sum = sum + ADD;
                if (sum > MAX_CNT) sum = MAX_CNT;
            end

            always_ff @(posedge clk) begin
                if (rst) cnt_q <= '0;
                else     cnt_q <= sum[CNT_W-1:0];
            end

            assign stall = (cnt_q != '0);
        end
    endgenerate
endmodule

// File: rtl/ep_ctl_mode_reg.sv
module ep_ctl_mode_reg
    import ep_mode_pkg::*;
#(
    parameter int STALL_PER_BYTE = 3,
    parameter int STALL_CNT_W    = 5
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cpu_wr,
    input  logic [7:0] cpu_wdata,
    input  logic       cpu_rd,
    output logic [7:0] cpu_rdata,
    output logic       wr_locked,
    input  logic       tok_done,
    input  logic [1:0] tok_type,
    input  logic       crc_ok,
    output logic [1:0] tok_resp,
    input  logic       hs_done,
    input  logic       hs_ack,
    output logic       ep_irq,
    input  logic       fifo_wr,
    output logic       cpu_stall
);
    ep_reg_t   reg_q, reg_d;
    resp_e     resp;
    tok_kind_e tok;
    logic      pend_q;
    tok_kind_e pend_tok_q;
    resp_e     pend_resp_q;
    logic      tok_acc, hs_fire, eng_upd, ack_ok;

    assign tok = tok_kind_e'(tok_type);

    ep_resp_decode u_dec (
        .mode (reg_q.mode),
        .tok  (tok),
        .resp (resp)
    );

    assign tok_acc = tok_done && (resp != RESP_NONE);
    assign hs_fire = hs_done && pend_q;
    assign eng_upd = tok_acc || hs_fire;
    assign ack_ok  = (pend_resp_q == RESP_ACK) && hs_ack;

    always_comb begin
        reg_d = reg_q;
        if (cpu_wr) begin
            reg_d.cpu_flag = cpu_wdata[7];
            if (!wr_locked && !eng_upd)
                reg_d[6:0] = cpu_wdata[6:0];
        end
        if (hs_fire) begin
            reg_d.acked = ack_ok;
            if (ack_ok)
                reg_d.mode = next_mode(reg_q.mode, pend_tok_q);
        end
        if (tok_acc) begin
            reg_d.setup = (tok == TOK_SETUP);
            reg_d.dval  = crc_ok && (tok != TOK_IN) && (resp == RESP_ACK);
            reg_d.acked = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_q       <= '0;
            pend_q      <= 1'b0;
            pend_tok_q  <= TOK_SETUP;
            pend_resp_q <= RESP_NONE;
            ep_irq      <= 1'b0;
        end else begin
            reg_q  <= reg_d;
            ep_irq <= hs_fire;
            if (tok_acc) begin
                pend_q      <= 1'b1;
                pend_tok_q  <= tok;
                pend_resp_q <= resp;
            end else if (hs_fire) begin
                pend_q <= 1'b0;
            end
        end
    end

    ep_lock_ctrl u_lock (
        .clk     (clk),
        .rst     (rst),
        .eng_upd (eng_upd),
        .cpu_rd  (cpu_rd),
        .locked  (wr_locked)
    );

    ep_stall_timer #(
        .CYC_PER_BYTE (STALL_PER_BYTE),
        .CNT_W        (STALL_CNT_W)
    ) u_stall (
        .clk     (clk),
        .rst     (rst),
        .byte_wr (fifo_wr),
        .stall   (cpu_stall)
    );

    assign cpu_rdata = reg_q;
    assign tok_resp  = resp;
endmodule

// File: rtl/ep_ctl_mode_reg_chk.sv
module ep_ctl_mode_reg_chk (
    input logic       clk,
    input logic       rst,
    input logic       cpu_wr,
    input logic       cpu_rd,
    input logic [7:0] cpu_rdata,
    input logic       wr_locked,
    input logic       tok_done,
    input logic [1:0] tok_type,
    input logic       crc_ok,
    input logic [1:0] tok_resp,
    input logic       hs_done,
    input logic       ep_irq,
    input logic       fifo_wr,
    input logic       cpu_stall,
    input logic       eng_upd,
    input logic       pend_q
);
    assert_wr_blocked_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_locked && cpu_wr && !eng_upd) |=> (cpu_rdata[6:0] == $past(cpu_rdata[6:0])));

    assert_eng_locks_R5: assert property (@(posedge clk) disable iff (rst)
        eng_upd |=> wr_locked);

    assert_rd_unlock_R6: assert property (@(posedge clk) disable iff (rst)
        (cpu_rd && !eng_upd) |=> !wr_locked);

    assert_irq_follows_R8: assert property (@(posedge clk) disable iff (rst)
        (hs_done && pend_q) |=> ep_irq);

    assert_irq_source_R8: assert property (@(posedge clk) disable iff (rst)
        (hs_done && !pend_q && !(tok_done && tok_resp != 2'd0)) |=> !ep_irq);

    assert_in_no_dval_R3: assert property (@(posedge clk) disable iff (rst)
        (tok_done && tok_type == 2'd1 && tok_resp != 2'd0) |=> !cpu_rdata[6]);

    assert_bad_crc_R4: assert property (@(posedge clk) disable iff (rst)
        (tok_done && tok_resp != 2'd0 && !crc_ok) |=> !cpu_rdata[6]);

    assert_stall_R9: assert property (@(posedge clk) disable iff (rst)
        fifo_wr |=> cpu_stall);
endmodule

bind ep_ctl_mode_reg ep_ctl_mode_reg_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .cpu_wr    (cpu_wr),
    .cpu_rd    (cpu_rd),
    .cpu_rdata (cpu_rdata),
    .wr_locked (wr_locked),
    .tok_done  (tok_done),
    .tok_type  (tok_type),
    .crc_ok    (crc_ok),
    .tok_resp  (tok_resp),
    .hs_done   (hs_done),
    .ep_irq    (ep_irq),
    .fifo_wr   (fifo_wr),
    .cpu_stall (cpu_stall),
    .eng_upd   (eng_upd),
    .pend_q    (pend_q)
);

// File: tb/ep_ctl_mode_reg_tb.sv
module ep_ctl_mode_reg_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cpu_wr = 1'b0, cpu_rd = 1'b0;
    logic [7:0] cpu_wdata = 8'h00;
    logic [7:0] cpu_rdata;
    logic       wr_locked;
    logic       tok_done = 1'b0, crc_ok = 1'b0;
    logic [1:0] tok_type = 2'd0;
    logic [1:0] tok_resp;
    logic       hs_done = 1'b0, hs_ack = 1'b0;
    logic       ep_irq;
    logic       fifo_wr = 1'b0;
    logic       cpu_stall;

    int n_vec = 0, n_bad = 0, cyc = 0;
    bit done = 0;

    int m_reg = 0, m_lock = 0, m_pend = 0, m_ptok = 0, m_presp = 0, m_irq = 0, m_cnt = 0;

    always #5 clk = ~clk;

    ep_ctl_mode_reg u_dut (
        .clk(clk), .rst(rst), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .cpu_rd(cpu_rd),
        .cpu_rdata(cpu_rdata), .wr_locked(wr_locked), .tok_done(tok_done),
        .tok_type(tok_type), .crc_ok(crc_ok), .tok_resp(tok_resp), .hs_done(hs_done),
        .hs_ack(hs_ack), .ep_irq(ep_irq), .fifo_wr(fifo_wr), .cpu_stall(cpu_stall)
    );

    function automatic int exp_resp(int mode, int tk);
        if (tk == 3) return 0;
        case (mode)
            1:  return (tk == 0) ? 1 : 2;
            2:  return (tk == 0) ? 1 : 3;
            3:  return (tk == 1) ? 2 : 1;
            6:  return (tk == 1) ? 3 : 1;
            7:  return (tk == 2) ? 2 : 1;
            15: return 1;
            default: return 0;
        endcase
    endfunction

    // reference model, updated on each rising edge
    always @(posedge clk) begin
        int rsp, nr, ack;
        bit tacc, hfire, eng;
        cyc++;
        if (rst) begin
            m_reg = 0; m_lock = 0; m_pend = 0; m_irq = 0; m_cnt = 0; m_ptok = 0; m_presp = 0;
        end else begin
            rsp   = exp_resp(m_reg & 15, int'(tok_type));
            tacc  = tok_done && rsp != 0;
            hfire = hs_done && m_pend != 0;
            eng   = tacc || hfire;
            nr    = m_reg;
            if (cpu_wr) begin
                nr = (nr & 'h7F) | (int'(cpu_wdata) & 'h80);
                if (m_lock == 0 && !eng) nr = (nr & 'h80) | (int'(cpu_wdata) & 'h7F);
            end
            if (hfire) begin
                ack = (m_presp == 1 && hs_ack) ? 1 : 0;
                nr  = (nr & ~'h10) | (ack << 4);
                if (ack != 0)
                    nr = (nr & ~'hF) | ((m_ptok == 1 && (m_reg & 15) == 15) ? 6 : 1);
            end
            if (tacc) begin
                nr = nr & ~'h70;
                if (tok_type == 2'd0) nr = nr | 'h20;
                if (crc_ok && tok_type != 2'd1 && rsp == 1) nr = nr | 'h40;
            end
            if (eng) m_lock = 1; else if (cpu_rd) m_lock = 0;
            if (tacc) begin m_pend = 1; m_ptok = int'(tok_type); m_presp = rsp; end
            else if (hfire) m_pend = 0;
            m_irq = hfire ? 1 : 0;
            m_cnt = m_cnt - ((m_cnt > 0) ? 1 : 0) + (fifo_wr ? 3 : 0);
            if (m_cnt > 31) m_cnt = 31;
            m_reg = nr;
        end
    end

    // per-cycle comparison away from the rising edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            n_vec++;
            if (cpu_rdata[3:0] != m_reg[3:0]) begin n_bad++; $display("FAIL R7 mode act=%h exp=%h", cpu_rdata[3:0], m_reg[3:0]); end
            if (cpu_rdata[6:4] != m_reg[6:4]) begin n_bad++; $display("FAIL R3 status act=%h exp=%h", cpu_rdata[6:4], m_reg[6:4]); end
            if (cpu_rdata[7] != m_reg[7])     begin n_bad++; $display("FAIL R10 bit7 act=%b exp=%b", cpu_rdata[7], m_reg[7]); end
            if (int'(wr_locked) != m_lock)    begin n_bad++; $display("FAIL R5 lock act=%b exp=%0d", wr_locked, m_lock); end
            if (int'(ep_irq) != m_irq)        begin n_bad++; $display("FAIL R8 irq act=%b exp=%0d", ep_irq, m_irq); end
            if (int'(cpu_stall) != (m_cnt > 0 ? 1 : 0)) begin n_bad++; $display("FAIL R9 stall act=%b cnt=%0d", cpu_stall, m_cnt); end
            if (int'(tok_resp) != exp_resp(m_reg & 15, int'(tok_type))) begin
                n_bad++; $display("FAIL R2 resp act=%0d exp=%0d", tok_resp, exp_resp(m_reg & 15, int'(tok_type)));
            end
        end
    end

    task automatic chk(string tag, int act, int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); #2;
    endtask

    task automatic cpu_write(logic [7:0] v);
        cpu_wr = 1'b1; cpu_wdata = v; tick(); cpu_wr = 1'b0;
    endtask

    task automatic cpu_read();
        cpu_rd = 1'b1; tick(); cpu_rd = 1'b0;
    endtask

    task automatic token(logic [1:0] t, logic good);
        tok_done = 1'b1; tok_type = t; crc_ok = good; tick(); tok_done = 1'b0; crc_ok = 1'b0;
    endtask

    task automatic handshake(logic a);
        hs_done = 1'b1; hs_ack = a; tick(); hs_done = 1'b0; hs_ack = 1'b0;
    endtask

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        // R1 reset state
        chk("R1 reg", cpu_rdata, 0);
        chk("R1 lock", wr_locked, 0);
        chk("R1 irq", ep_irq, 0);
        chk("R1 stall", cpu_stall, 0);

        // R10 full write when unlocked
        cpu_write(8'hF3);
        chk("R10 write", cpu_rdata, 'hF3);

        // R2 full decode sweep
        for (int m = 0; m < 16; m++) begin
            cpu_write(8'(m));
            for (int t = 0; t < 4; t++) begin
                tok_type = 2'(t); #1;
                chk("R2 resp", tok_resp, exp_resp(m, t));
            end
        end

        // R3, R5, R7, R8: OUT in ACK-OUT mode
        cpu_write(8'h03);
        token(2'd2, 1'b1);
        chk("R3 out dval", cpu_rdata, 'h43);
        chk("R5 armed", wr_locked, 1);
        cpu_write(8'h81);
        chk("R5 blocked", cpu_rdata, 'hC3);
        handshake(1'b1);
        chk("R7 rewrite", cpu_rdata, 'hD1);
        chk("R8 irq hi", ep_irq, 1);
        tick();
        chk("R8 irq lo", ep_irq, 0);

        // R6 read releases
        cpu_read();
        chk("R6 unlock", wr_locked, 0);
        cpu_write(8'h0F);
        chk("R10 after unlock", cpu_rdata, 'h0F);

        // R4 bad CRC SETUP
        token(2'd0, 1'b0);
        chk("R4 no dval", cpu_rdata, 'h2F);
        handshake(1'b0);
        chk("R4 irq", ep_irq, 1);
        chk("R7 no ack keeps mode", cpu_rdata, 'h2F);

        // R7 mode 15 IN then status OUT
        cpu_read(); cpu_write(8'h0F);
        token(2'd1, 1'b1);
        chk("R3 in", cpu_rdata, 'h0F);
        handshake(1'b1);
        chk("R7 in->status", cpu_rdata, 'h16);
        cpu_read();
        token(2'd2, 1'b1);
        chk("R3 status out", cpu_rdata, 'h46);
        handshake(1'b1);
        chk("R7 status->nak", cpu_rdata, 'h51);

        // R3/R8 ignored token and stray handshake
        cpu_read(); cpu_write(8'h00);
        token(2'd2, 1'b1);
        chk("R3 ignored reg", cpu_rdata, 'h00);
        chk("R3 ignored lock", wr_locked, 0);
        handshake(1'b1);
        chk("R8 stray hs", ep_irq, 0);

        // R6 read in same cycle as engine update
        cpu_write(8'h03);
        cpu_rd = 1'b1; tok_done = 1'b1; tok_type = 2'd2; crc_ok = 1'b1; tick();
        cpu_rd = 1'b0; tok_done = 1'b0; crc_ok = 1'b0;
        chk("R6 engine wins", wr_locked, 1);
        handshake(1'b1);
        cpu_read();

        // R9 stall length and saturation
        fifo_wr = 1'b1; tick(); fifo_wr = 1'b0;
        chk("R9 s1", cpu_stall, 1); tick();
        chk("R9 s2", cpu_stall, 1); tick();
        chk("R9 s3", cpu_stall, 1); tick();
        chk("R9 end", cpu_stall, 0);
        fifo_wr = 1'b1; repeat (20) tick(); fifo_wr = 1'b0;
        repeat (30) tick();
        chk("R9 sat hi", cpu_stall, 1);
        tick();
        chk("R9 sat lo", cpu_stall, 0);

        repeat (3) tick();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    always @(posedge clk) begin
        if (cyc > 50000 && !done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog act=%0d exp=finish", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule